// File: doc/BRIEF.md
# Two-Pel Coarse Motion Search Engine

This block performs the first, coarse pass of block-matching motion estimation for one macroblock. It works on 2:1 subsampled data in both directions, so the 16x16 macroblock becomes an 8x8 template and every step in the search window is two pels. An array of 32 parallel sum-of-absolute-difference (SAD) elements scores 32 horizontally adjacent candidate displacements at a time. The engine walks the candidate rectangle in raster order, one group of 32 after another, and keeps the cheapest candidate. It reports that candidate's two-pel motion vector, in full-pel units, together with its SAD. Full-pel and half-pel refinement stages downstream consume this result.

The candidate rectangle is placed around a base vector supplied with the start pulse, in two-pel units. A base of zero gives the fixed window. A non-zero base moves the whole window (area hopping), which lets coarse vectors reach much further than the fixed window allows. The engine clamps the base so that no candidate leaves the hopping limits. Template and reference pixels come from an external window buffer through two read ports with a latency of one cycle. A start pulse launches a search, and a one-cycle done pulse marks a new result.

Top module: `coarse_mv_search`

## Requirements
- R1: While reset is held and after its release, `doneO` is 0, `mvXO` and `mvYO` are 0 and `sadO` is 0.
- R2: `startI` is acted on only while the engine is idle. Each accepted start yields exactly one `doneO` pulse, one cycle long. A start pulse during a running search changes neither that search's result nor the number of done pulses.
- R3: `sadO` is the exact sum, up to the maximum of 64 x 255 = 16320, with no wrap-around.
- R4: The reported vector and SAD belong to a candidate whose SAD is the minimum over the whole candidate set.
- R5: When several candidates tie for the minimum, the one scanned first is reported. The vertical offset ascending is the outer order and the horizontal offset ascending is the inner order.
- R6: A candidate (x, y) in two-pel units is baseX + ox and baseY + oy, with ox from X_MIN to X_MIN + 32*H_GROUPS - 1 and oy from Y_MIN to Y_MIN + V_CAND - 1. Its SAD is the sum over r, c in 0..7 of |tpl[8r+c] - ref(x+c, y+r)|. The engine reports it as `mvXO` = 2x and `mvYO` = 2y full pels, which are always even.
- R7: The base vector is first clamped per axis into [-HOP_X - X_MIN, HOP_X - X_MAX] and [-HOP_Y - Y_MIN, HOP_Y - Y_MAX], where X_MAX and Y_MAX are the largest offsets. As a result, every candidate satisfies |x| <= HOP_X and |y| <= HOP_Y.
- R8: `mvXO`, `mvYO` and `sadO` change only on the edge that raises `doneO`. They hold through idle time and through the next search.
- R9: A template read with `tplRdO` at address 8r+c, and a reference read with `refRdO` at signed window coordinates (`refXO`, `refYO`), both expect their pixel on the matching input in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startI | input | 1 | One-cycle request to begin a search |
| baseXI | input | 10 | Signed horizontal base vector, two-pel units, sampled with start |
| baseYI | input | 10 | Signed vertical base vector, two-pel units, sampled with start |
| tplRdO | output | 1 | Template read request |
| tplAddrO | output | 6 | Template pixel index, 8*row + column |
| tplPixI | input | 8 | Template pixel, one cycle after the request |
| refRdO | output | 1 | Reference read request |
| refXO | output | 10 | Signed reference column, two-pel units |
| refYO | output | 10 | Signed reference row, two-pel units |
| refPixI | input | 8 | Reference pixel, one cycle after the request |
| doneO | output | 1 | One-cycle pulse marking a new result |
| mvXO | output | 11 | Signed horizontal motion vector, full pels |
| mvYO | output | 11 | Signed vertical motion vector, full pels |
| sadO | output | 14 | SAD of the reported candidate |

## Verification
A corrupted accumulator or a wrong mux index in the SAD array stays hidden until the group's scan. It then shows up as a wrong vector or SAD at the next done pulse, one full search later. A broken tie rule or a broken clamp only appears on flat images or on large base vectors. The bench therefore uses planted matches at the first and last candidates, uniform pictures, the maximum-difference picture, and base vectors far outside the clamp range. A control fault that restarts, skips or repeats a group shows up as a missing, doubled or late done pulse, or as a result that differs from the scoreboard's full search.

// File: rtl/cms_pkg.sv
package cms_pkg;
  localparam int PIX_W   = 8;
  localparam int NUM_PE  = 32;
  localparam int TPL_DIM = 8;
  localparam int TPL_N   = TPL_DIM * TPL_DIM;
  localparam int LINE_N  = NUM_PE + TPL_DIM - 1;
  localparam int SAD_MAX = TPL_N * ((1 << PIX_W) - 1);
  localparam int SAD_W   = $clog2(SAD_MAX + 1);
  localparam int TPL_AW  = $clog2(TPL_N);
  localparam int LINE_AW = $clog2(LINE_N);
  localparam int PE_AW   = $clog2(NUM_PE);
  localparam int COL_AW  = $clog2(TPL_DIM);
  localparam int CNT_W   = $clog2(LINE_N + 1);
  localparam int COORD_W = 10;
  localparam int MV_W    = COORD_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_CALC, ST_SCAN, ST_FIN
  } state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic                       capRef;
    logic                       capTpl;
    logic [LINE_AW-1:0]         capIdx;
    logic                       calcEn;
    logic                       accClr;
    logic [COL_AW-1:0]          calcCol;
    logic                       scanEn;
    logic                       scanFirst;
    logic [PE_AW-1:0]           scanIdx;
    logic signed [COORD_W-1:0]  candX;
    logic signed [COORD_W-1:0]  candY;
    logic                       outLatch;
  } strobe_t;
endpackage

// File: rtl/cms_sad_pe.sv
module cms_sad_pe
  import cms_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             enI,
  input  logic             clrI,
  input  logic [PIX_W-1:0] aI,
  input  logic [PIX_W-1:0] bI,
  output logic [SAD_W-1:0] accO
);
  logic [PIX_W-1:0] absDiff;

  always_comb begin
    absDiff = (aI > bI) ? (aI - bI) : (bI - aI);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accO <= '0;
    end else if (enI) begin
      accO <= clrI ? SAD_W'(absDiff) : accO + SAD_W'(absDiff);
    end
  end

  // R3: accumulation never wraps back below its previous value
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (enI && !clrI) |=> (accO >= $past(accO)));
endmodule

// File: rtl/cms_ctrl.sv
module cms_ctrl
  import cms_pkg::*;
#(
  parameter int H_GROUPS = 4,
  parameter int V_CAND   = 57,
  parameter int X_MIN    = -64,
  parameter int Y_MIN    = -28,
  parameter int HOP_X    = 105,
  parameter int HOP_Y    = 56
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      startI,
  input  logic signed [COORD_W-1:0] baseXI,
  input  logic signed [COORD_W-1:0] baseYI,
  output logic                      tplRdO,
  output logic [TPL_AW-1:0]         tplAddrO,
  output logic                      refRdO,
  output logic signed [COORD_W-1:0] refXO,
  output logic signed [COORD_W-1:0] refYO,
  output logic                      busyO,
  output strobe_t                   stO
);
  localparam int X_MAX = X_MIN + NUM_PE * H_GROUPS - 1;
  localparam int Y_MAX = Y_MIN + V_CAND - 1;
  localparam int X_LO  = -HOP_X - X_MIN;
  localparam int X_HI  = HOP_X - X_MAX;
  localparam int Y_LO  = -HOP_Y - Y_MIN;
  localparam int Y_HI  = HOP_Y - Y_MAX;
  localparam int G_W   = $clog2(H_GROUPS + 1);
  localparam int V_W   = $clog2(V_CAND + 1);

  state_t                    state;
  logic [CNT_W-1:0]          cnt;
  logic [COL_AW-1:0]         rowCnt;
  logic [G_W-1:0]            gCnt;
  logic [V_W-1:0]            vCnt;
  logic signed [COORD_W-1:0] baseXq;
  logic signed [COORD_W-1:0] baseYq;
  logic signed [COORD_W-1:0] xGrp;
  logic signed [COORD_W-1:0] yCur;

  function automatic int clampInt(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  always_comb begin
    xGrp = COORD_W'(int'(baseXq) + X_MIN + int'(gCnt) * NUM_PE);
    yCur = COORD_W'(int'(baseYq) + Y_MIN + int'(vCnt));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      rowCnt <= '0;
      gCnt   <= '0;
      vCnt   <= '0;
      baseXq <= '0;
      baseYq <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startI) begin
            baseXq <= COORD_W'(clampInt(int'(baseXI), X_LO, X_HI));
            baseYq <= COORD_W'(clampInt(int'(baseYI), Y_LO, Y_HI));
            cnt    <= '0;
            rowCnt <= '0;
            gCnt   <= '0;
            vCnt   <= '0;
            state  <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (cnt == CNT_W'(LINE_N)) begin
            cnt   <= '0;
            state <= ST_CALC;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_CALC: begin
          if (cnt == CNT_W'(TPL_DIM - 1)) begin
            cnt <= '0;
            if (rowCnt == COL_AW'(TPL_DIM - 1)) begin
              rowCnt <= '0;
              state  <= ST_SCAN;
            end else begin
              rowCnt <= rowCnt + 1'b1;
              state  <= ST_LOAD;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SCAN: begin
          if (cnt == CNT_W'(NUM_PE - 1)) begin
            cnt   <= '0;
            state <= ST_LOAD;
            if (gCnt == G_W'(H_GROUPS - 1)) begin
              gCnt <= '0;
              if (vCnt == V_W'(V_CAND - 1)) begin
                state <= ST_FIN;
              end else begin
                vCnt <= vCnt + 1'b1;
              end
            end else begin
              gCnt <= gCnt + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stO      = '0;
    tplRdO   = 1'b0;
    refRdO   = 1'b0;
    tplAddrO = TPL_AW'(int'(rowCnt) * TPL_DIM + int'(cnt[COL_AW-1:0]));
    refXO    = COORD_W'(int'(xGrp) + int'(cnt));
    refYO    = COORD_W'(int'(yCur) + int'(rowCnt));
    busyO    = (state != ST_IDLE);
    case (state)
      ST_LOAD: begin
        refRdO       = (cnt < CNT_W'(LINE_N));
        tplRdO       = (cnt < CNT_W'(TPL_DIM));
        stO.capRef   = (cnt != '0);
        stO.capTpl   = (cnt != '0) && (cnt <= CNT_W'(TPL_DIM));
        stO.capIdx   = LINE_AW'(cnt - CNT_W'(1));
      end
      ST_CALC: begin
        stO.calcEn  = 1'b1;
        stO.calcCol = cnt[COL_AW-1:0];
        stO.accClr  = (rowCnt == '0) && (cnt == '0);
      end
      ST_SCAN: begin
        stO.scanEn    = 1'b1;
        stO.scanIdx   = cnt[PE_AW-1:0];
        stO.candX     = COORD_W'(int'(xGrp) + int'(cnt));
        stO.candY     = yCur;
        stO.scanFirst = (gCnt == '0) && (vCnt == '0) && (cnt == '0);
      end
      ST_FIN:  stO.outLatch = 1'b1;
      default: ;
    endcase
  end

  // R7: every reference fetch stays within the clamped hop limits plus template extent
  a_r7_ref_in_range: assert property (@(posedge clk) disable iff (!rstN)
    refRdO |-> ((int'(refXO) >= -HOP_X) && (int'(refXO) <= HOP_X + TPL_DIM - 1) &&
                (int'(refYO) >= -HOP_Y) && (int'(refYO) <= HOP_Y + TPL_DIM - 1)));

  // R9: template reads only occur while reference reads are also being issued
  a_r9_tpl_with_ref: assert property (@(posedge clk) disable iff (!rstN)
    tplRdO |-> refRdO);
endmodule

// File: rtl/cms_datapath.sv
module cms_datapath
  import cms_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   st,
  input  logic [PIX_W-1:0]          tplPixI,
  input  logic [PIX_W-1:0]          refPixI,
  output logic                      doneO,
  output logic signed [MV_W-1:0]    mvXO,
  output logic signed [MV_W-1:0]    mvYO,
  output logic [SAD_W-1:0]          sadO
);
  logic [PIX_W-1:0]          lineBuf [LINE_N];
  logic [PIX_W-1:0]          tplRow  [TPL_DIM];
  logic [SAD_W-1:0]          accArr  [NUM_PE];
  logic [SAD_W-1:0]          candSad;
  logic [SAD_W-1:0]          bestSad;
  logic signed [COORD_W-1:0] bestX;
  logic signed [COORD_W-1:0] bestY;

  always_ff @(posedge clk) begin
    if (st.capRef) lineBuf[st.capIdx] <= refPixI;
    if (st.capTpl) tplRow[st.capIdx[COL_AW-1:0]] <= tplPixI;
  end

  for (genvar k = 0; k < NUM_PE; k++) begin : g_pe
    cms_sad_pe u_pe (
      .clk  (clk),
      .rstN (rstN),
      .enI  (st.calcEn),
      .clrI (st.accClr),
      .aI   (tplRow[st.calcCol]),
      .bI   (lineBuf[LINE_AW'(k) + LINE_AW'(st.calcCol)]),
      .accO (accArr[k])
    );
  end

  always_comb begin
    candSad = accArr[st.scanIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bestSad <= '0;
      bestX   <= '0;
      bestY   <= '0;
      doneO   <= 1'b0;
      mvXO    <= '0;
      mvYO    <= '0;
      sadO    <= '0;
    end else begin
      if (st.scanEn && (st.scanFirst || (candSad < bestSad))) begin
        bestSad <= candSad;
        bestX   <= st.candX;
        bestY   <= st.candY;
      end
      doneO <= st.outLatch;
      if (st.outLatch) begin
        mvXO <= MV_W'(2 * int'(bestX));
        mvYO <= MV_W'(2 * int'(bestY));
        sadO <= bestSad;
      end
    end
  end

  // R2: done lasts exactly one cycle
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneO |=> !doneO);

  // R3: reported SAD never exceeds the largest reachable sum
  a_r3_sad_bound: assert property (@(posedge clk) disable iff (!rstN)
    doneO |-> (int'(sadO) <= SAD_MAX));

  // R4: the running best never gets worse after the first candidate
  a_r4_best_not_worse: assert property (@(posedge clk) disable iff (!rstN)
    (st.scanEn && !st.scanFirst) |=> (bestSad <= $past(bestSad)));
endmodule

// File: rtl/coarse_mv_search.sv
module coarse_mv_search
  import cms_pkg::*;
#(
  parameter int H_GROUPS = 4,
  parameter int V_CAND   = 57,
  parameter int X_MIN    = -64,
  parameter int Y_MIN    = -28,
  parameter int HOP_X    = 105,
  parameter int HOP_Y    = 56
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      startI,
  input  logic signed [COORD_W-1:0] baseXI,
  input  logic signed [COORD_W-1:0] baseYI,
  output logic                      tplRdO,
  output logic [TPL_AW-1:0]         tplAddrO,
  input  logic [PIX_W-1:0]          tplPixI,
  output logic                      refRdO,
  output logic signed [COORD_W-1:0] refXO,
  output logic signed [COORD_W-1:0] refYO,
  input  logic [PIX_W-1:0]          refPixI,
  output logic                      doneO,
  output logic signed [MV_W-1:0]    mvXO,
  output logic signed [MV_W-1:0]    mvYO,
  output logic [SAD_W-1:0]          sadO
);
  strobe_t st;
  logic    busy;

  cms_ctrl #(
    .H_GROUPS (H_GROUPS),
    .V_CAND   (V_CAND),
    .X_MIN    (X_MIN),
    .Y_MIN    (Y_MIN),
    .HOP_X    (HOP_X),
    .HOP_Y    (HOP_Y)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startI   (startI),
    .baseXI   (baseXI),
    .baseYI   (baseYI),
    .tplRdO   (tplRdO),
    .tplAddrO (tplAddrO),
    .refRdO   (refRdO),
    .refXO    (refXO),
    .refYO    (refYO),
    .busyO    (busy),
    .stO      (st)
  );

  cms_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .tplPixI (tplPixI),
    .refPixI (refPixI),
    .doneO   (doneO),
    .mvXO    (mvXO),
    .mvYO    (mvYO),
    .sadO    (sadO)
  );

  // R8: result ports hold while the engine sits idle without a new request
  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !startI) |=> ($stable(mvXO) && $stable(mvYO) && $stable(sadO)));

  // R8: result ports move only together with a done pulse
  a_r8_change_with_done: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(mvXO) || !$stable(mvYO) || !$stable(sadO)) |-> doneO);
endmodule

// File: tb/test_coarse_mv_search.sv
module test_coarse_mv_search;
  localparam int HG = 2, VC = 4, XMN = -32, YMN = -2, HX = 40, HY = 6;
  localparam int XMX = XMN + 32 * HG - 1;
  localparam int YMX = YMN + VC - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startI = 1'b0;
  logic signed [9:0] baseXI = '0;
  logic signed [9:0] baseYI = '0;
  logic tplRdO, refRdO, doneO;
  logic [5:0] tplAddrO;
  logic [7:0] tplPixI = '0;
  logic [7:0] refPixI = '0;
  logic signed [9:0] refXO, refYO;
  logic signed [10:0] mvXO, mvYO;
  logic [13:0] sadO;

  always #2 clk = ~clk;

  coarse_mv_search #(.H_GROUPS(HG), .V_CAND(VC), .X_MIN(XMN), .Y_MIN(YMN),
                     .HOP_X(HX), .HOP_Y(HY)) i_coarse_mv_search (
    .clk(clk), .rstN(rstN), .startI(startI), .baseXI(baseXI), .baseYI(baseYI),
    .tplRdO(tplRdO), .tplAddrO(tplAddrO), .tplPixI(tplPixI),
    .refRdO(refRdO), .refXO(refXO), .refYO(refYO), .refPixI(refPixI),
    .doneO(doneO), .mvXO(mvXO), .mvYO(mvYO), .sadO(sadO));

  typedef struct { int x; int y; int s; string tag; } exp_t;
  exp_t expQ[$];
  int nChecks = 0, nFails = 0, doneCount = 0, cyc = 0;
  int lastX = 0, lastY = 0, lastS = 0;
  int refMode = 0, seed = 0;
  logic [7:0] tplMem [64];

  function automatic int refVal(input int x, input int y);
    logic [31:0] h;
    if (refMode == 1) return 77;
    if (refMode == 2) return 0;
    h = 32'(x * 1103515245 + y * 12345 + seed);
    h = h ^ (h >> 13);
    h = h * 32'd2654435761;
    h = h ^ (h >> 16);
    return int'(h[7:0]);
  endfunction

  function automatic int clampInt(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  // window buffer model, one-cycle read latency (R9)
  always @(posedge clk) begin
    if (tplRdO) tplPixI <= tplMem[tplAddrO];
    if (refRdO) refPixI <= 8'(refVal(int'(refXO), int'(refYO)));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nFails++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && doneO) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(int'(mvXO) == e.x, "R4", {e.tag, " mvX"}, int'(mvXO), e.x);
        check(int'(mvYO) == e.y, "R4", {e.tag, " mvY"}, int'(mvYO), e.y);
        check(int'(sadO) == e.s, "R4", {e.tag, " sad"}, int'(sadO), e.s);
        check((mvXO[0] == 1'b0) && (mvYO[0] == 1'b0), "R6", {e.tag, " even"},
              int'(mvXO), e.x);
      end
      lastX = int'(mvXO);
      lastY = int'(mvYO);
      lastS = int'(sadO);
      doneCount++;
    end
  end

  // full search model built from R5, R6 and R7
  task automatic model(input int bx, input int by, input string tag);
    exp_t e;
    int cbx, cby, best;
    bit first;
    cbx = clampInt(bx, -HX - XMN, HX - XMX);
    cby = clampInt(by, -HY - YMN, HY - YMX);
    first = 1'b1;
    best = 0;
    e.tag = tag;
    for (int oy = YMN; oy <= YMX; oy++) begin
      for (int ox = XMN; ox <= XMX; ox++) begin
        int s;
        s = 0;
        for (int r = 0; r < 8; r++) begin
          for (int c = 0; c < 8; c++) begin
            int d;
            d = int'(tplMem[8 * r + c]) - refVal(cbx + ox + c, cby + oy + r);
            s += (d < 0) ? -d : d;
          end
        end
        if (first || s < best) begin
          first = 1'b0;
          best = s;
          e.x = 2 * (cbx + ox);
          e.y = 2 * (cby + oy);
        end
      end
    end
    e.s = best;
    expQ.push_back(e);
  endtask

  task automatic runSearch(input int bx, input int by, input string tag,
                           input bit midStart);
    int prev;
    model(bx, by, tag);
    prev = doneCount;
    @(negedge clk);
    baseXI = 10'(bx);
    baseYI = 10'(by);
    startI = 1'b1;
    @(negedge clk);
    startI = 1'b0;
    if (midStart) begin
      repeat (200) @(negedge clk);
      baseXI = 10'(bx + 5);
      baseYI = 10'(by + 1);
      startI = 1'b1;
      @(negedge clk);
      startI = 1'b0;
    end
    while (doneCount == prev) @(negedge clk);
    @(negedge clk);
    check(doneO == 1'b0, "R2", {tag, " done one cycle"}, int'(doneO), 0);
  endtask

  task automatic plantAt(input int px, input int py);
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++)
        tplMem[8 * r + c] = 8'(refVal(px + c, py + r));
  endtask

  task automatic randomTpl(input int s);
    for (int i = 0; i < 64; i++) tplMem[i] = 8'((i * 97 + s * 31) ^ (i * i + s));
  endtask

  initial begin
    for (int i = 0; i < 64; i++) tplMem[i] = '0;
    repeat (3) @(negedge clk);
    check(doneO == 1'b0, "R1", "done in reset", int'(doneO), 0);
    check(mvXO == '0 && mvYO == '0, "R1", "mv in reset", int'(mvXO), 0);
    check(sadO == '0, "R1", "sad in reset", int'(sadO), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(doneO == 1'b0 && sadO == '0, "R1", "after release", int'(sadO), 0);

    // planted match at the first candidate (R6, R9)
    refMode = 0; seed = 11;
    plantAt(XMN, YMN);
    runSearch(0, 0, "first corner", 1'b0);
    check(lastX == 2 * XMN && lastY == 2 * YMN, "R6", "R9 first corner mv",
          lastX, 2 * XMN);
    check(lastS == 0, "R9", "first corner sad", lastS, 0);

    // planted match at the last candidate (R6)
    seed = 23;
    plantAt(XMX, YMX);
    runSearch(0, 0, "last corner", 1'b0);
    check(lastX == 2 * XMX && lastY == 2 * YMX, "R6", "last corner mv",
          lastX, 2 * XMX);

    // general minimum with an unrelated template (R4)
    seed = 5;
    randomTpl(3);
    runSearch(3, -1, "random tpl", 1'b0);

    // uniform picture: every candidate ties (R5)
    refMode = 1;
    for (int i = 0; i < 64; i++) tplMem[i] = 8'd77;
    runSearch(2, 1, "flat ties", 1'b0);
    check(lastX == 2 * (2 + XMN) && lastY == 2 * (1 + YMN), "R5", "earliest tie",
          lastX, 2 * (2 + XMN));

    // largest possible difference (R3)
    refMode = 2;
    for (int i = 0; i < 64; i++) tplMem[i] = 8'd255;
    runSearch(0, 0, "max sad", 1'b0);
    check(lastS == 16320, "R3", "max sad no wrap", lastS, 16320);

    // base far positive, clamped to (9,5) (R7)
    refMode = 0; seed = 41;
    plantAt(29, 5);
    runSearch(100, 100, "hop positive", 1'b0);
    check(lastX == 58 && lastY == 10, "R7", "clamped hop positive", lastX, 58);

    // base far negative, clamped to (-8,-4) (R7)
    seed = 57;
    plantAt(-40, -6);
    runSearch(-100, -100, "hop negative", 1'b0);
    check(lastX == -80 && lastY == -12, "R7", "clamped hop negative", lastX, -80);

    // start during a search is ignored (R2)
    seed = 73;
    randomTpl(9);
    runSearch(1, 0, "busy start", 1'b1);
    check(expQ.size() == 0, "R2", "queue drained", expQ.size(), 0);

    // outputs hold while idle and through input changes (R8)
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      baseXI = 10'(i);
      baseYI = 10'(-i);
    end
    check(int'(mvXO) == lastX && int'(mvYO) == lastY && int'(sadO) == lastS,
          "R8", "hold while idle", int'(mvXO), lastX);
    check(doneCount == 8, "R2", "done count", doneCount, 8);

    summary();
    $finish;
  end
endmodule